// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block drives the memory traffic a processor needs when it takes a trap or interrupt, and again when it returns from one. When an entry is requested it fetches the new program counter and the new status word from a two-word vector, samples the stack pointer, and saves the interrupted status word and program counter on the stack. When a return is requested it pops the program counter and then the status word, and hands both back. All traffic goes through one request/acknowledge/error memory port. Each access holds its request until the memory answers.

When entry or return completes, the new program counter, status word and stack pointer are shown on registered outputs, together with a one-cycle completion pulse. A memory fault during a sequence restarts entry through a fixed bus-error vector. A second fault while that bus-error entry is running ends the sequence with a one-cycle fatal pulse. The caller may cancel an entry at the point where a vector word arrives. A caller that flags a severe stack fault gets a zero saved in place of the status word.

Top module: `trap_seq_top`

## Requirements
- R1: After reset the block is idle (`busy` low), `mem_req`, `done` and `fatal` are low, and `pc_out`, `psw_out` and `sp_out` are zero.
- R2: An entry makes exactly four accesses in this order: read at the vector address, read at vector+2, write of the saved status word at SP-2, then write of the saved program counter at SP-4. `mem_we` is 1 for writes and 0 for reads.
- R3: The stack pointer is sampled from `sp_in` only after both vector reads have finished, not when the entry starts.
- R4: When an entry completes, `pc_out` holds the word read at the vector, `psw_out` holds the word read at vector+2, and `sp_out` holds SP-4. These appear in the same cycle as a one-cycle `done` pulse, and `busy` is low in that cycle.
- R5: A request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until a cycle in which `mem_ack` or `mem_err` is high. It drops in the following cycle, and any number of wait cycles is accepted.
- R6: If `abort_req` is high in the cycle a vector read is acknowledged, the block returns to idle. It makes no further access, does not pulse `done`, and leaves the outputs unchanged. This holds after either vector read.
- R7: If `stack_severe` is high when the entry starts, the word written at SP-2 is zero instead of the status word.
- R8: A return reads the program counter at `sp_in`, then the status word at `sp_in`+2. It then presents them on `pc_out`/`psw_out` with `sp_out` = `sp_in`+4 and a `done` pulse.
- R9: A `mem_err` answer restarts the entry sequence with vector address 4. The same saved program counter and status word are used, and the stack pointer is sampled again.
- R10: A `mem_err` during the vector-4 entry started by R9 ends the sequence with a one-cycle `fatal` pulse, no `done`, and a return to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_trap | input | 1 | Start an entry sequence (sampled while idle, has priority) |
| start_ret | input | 1 | Start a return sequence (sampled while idle) |
| abort_req | input | 1 | Cancel the entry when a vector read is acknowledged |
| stack_severe | input | 1 | Save zero instead of the status word |
| vec_addr | input | W | Vector address for the entry |
| cur_pc | input | W | Program counter to save |
| cur_psw | input | W | Status word to save |
| sp_in | input | W | Current stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | W | Access address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access faulted |
| pc_out | output | W | New program counter |
| psw_out | output | W | New status word |
| sp_out | output | W | Stack pointer after the sequence |
| done | output | 1 | One-cycle completion pulse |
| fatal | output | 1 | One-cycle fatal failure pulse |
| busy | output | 1 | Sequence in progress |

## Verification
The bench builds the block with its default parameters: 16-bit words, a stack step of 2, and the bus-error vector at 4. With these values a 256-word bench memory covers every vector and stack address used. Because the bus-error vector is a low address, a fault placed on address 4 reaches the double-fault path that ends in `fatal`. The memory's answer latency varies from zero to three wait cycles, which exercises the held-request rule at every step of the sequence.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [4:0] {
    S_IDLE,
    S_VPC, S_VPC_W,      // vector word 0
    S_VPS, S_VPS_W,      // vector word 1
    S_GETSP, S_DECSP,
    S_PPS, S_PPS_W,      // save status word
    S_PPC, S_PPC_W,      // save program counter
    S_RPC, S_RPC_W,      // return: pop program counter
    S_RPS, S_RPS_W,      // return: pop status word
    S_RNEW,
    S_MERR, S_FAIL
  } seq_state_e;
endpackage

// File: rtl/trap_seq_step.sv
module trap_seq_step #(
  parameter int W     = 16,
  parameter int STEP  = 2,
  parameter bit DOWN  = 1'b0
) (
  input  logic [W-1:0] base,
  output logic [W-1:0] result
);
  generate
    if (DOWN) begin : g_dn
      assign result = base - W'(STEP);
    end else begin : g_up
      assign result = base + W'(STEP);
    end
  endgenerate
endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
  import trap_seq_pkg::*;
#(
  parameter int W       = 16,
  parameter int STEP    = 2,
  parameter int ERR_VEC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_trap,
  input  logic         start_ret,
  input  logic         abort_req,
  input  logic         stack_severe,
  input  logic [W-1:0] vec_addr,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] cur_psw,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack,
  input  logic         mem_err,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] psw_out,
  output logic [W-1:0] sp_out,
  output logic         done,
  output logic         fatal,
  output logic         busy
);
  seq_state_e   state;
  logic [W-1:0] vec_q, opc_q, opsw_q, sp_q, npc_q, npsw_q;
  logic         sev_q, in_err;
  logic [W-1:0] sp_up, sp_dn, vec_nxt;

  trap_seq_step #(.W(W), .STEP(STEP), .DOWN(1'b0)) u_sp_up  (.base(sp_q),  .result(sp_up));
  trap_seq_step #(.W(W), .STEP(STEP), .DOWN(1'b1)) u_sp_dn  (.base(sp_q),  .result(sp_dn));
  trap_seq_step #(.W(W), .STEP(STEP), .DOWN(1'b0)) u_vec_up (.base(vec_q), .result(vec_nxt));

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      vec_q     <= '0;
      opc_q     <= '0;
      opsw_q    <= '0;
      sp_q      <= '0;
      npc_q     <= '0;
      npsw_q    <= '0;
      sev_q     <= 1'b0;
      in_err    <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      pc_out    <= '0;
      psw_out   <= '0;
      sp_out    <= '0;
      done      <= 1'b0;
      fatal     <= 1'b0;
    end else begin
      done  <= 1'b0;
      fatal <= 1'b0;
      case (state)
        S_IDLE: begin
          in_err <= 1'b0;
          opc_q  <= cur_pc;
          opsw_q <= cur_psw;
          sev_q  <= stack_severe;
          if (start_trap) begin
            vec_q <= vec_addr;
            state <= S_VPC;
          end else if (start_ret) begin
            sp_q  <= sp_in;
            state <= S_RPC;
          end
        end
        S_VPC: begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= vec_q;
          state   <= S_VPC_W;
        end
        S_VPC_W: begin
          if (mem_err) begin
            mem_req <= 1'b0; state <= S_MERR;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            npc_q   <= mem_rdata;
            state   <= abort_req ? S_IDLE : S_VPS;
          end
        end
        S_VPS: begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= vec_nxt;
          state   <= S_VPS_W;
        end
        S_VPS_W: begin
          if (mem_err) begin
            mem_req <= 1'b0; state <= S_MERR;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            npsw_q  <= mem_rdata;
            state   <= abort_req ? S_IDLE : S_GETSP;
          end
        end
        S_GETSP: begin
          sp_q  <= sp_in;
          state <= S_DECSP;
        end
        S_DECSP: begin
          sp_q  <= sp_dn;
          state <= S_PPS;
        end
        S_PPS: begin
          mem_req   <= 1'b1; mem_we <= 1'b1; mem_addr <= sp_q;
          mem_wdata <= sev_q ? '0 : opsw_q;
          state     <= S_PPS_W;
        end
        S_PPS_W: begin
          if (mem_err) begin
            mem_req <= 1'b0; state <= S_MERR;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            sp_q    <= sp_dn;
            state   <= S_PPC;
          end
        end
        S_PPC: begin
          mem_req   <= 1'b1; mem_we <= 1'b1; mem_addr <= sp_q;
          mem_wdata <= opc_q;
          state     <= S_PPC_W;
        end
        S_PPC_W: begin
          if (mem_err) begin
            mem_req <= 1'b0; state <= S_MERR;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            pc_out  <= npc_q;
            psw_out <= npsw_q;
            sp_out  <= sp_q;
            done    <= 1'b1;
            state   <= S_IDLE;
          end
        end
        S_RPC: begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= sp_q;
          state   <= S_RPC_W;
        end
        S_RPC_W: begin
          if (mem_err) begin
            mem_req <= 1'b0; state <= S_MERR;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            npc_q   <= mem_rdata;
            sp_q    <= sp_up;
            state   <= S_RPS;
          end
        end
        S_RPS: begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= sp_q;
          state   <= S_RPS_W;
        end
        S_RPS_W: begin
          if (mem_err) begin
            mem_req <= 1'b0; state <= S_MERR;
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            npsw_q  <= mem_rdata;
            sp_q    <= sp_up;
            state   <= S_RNEW;
          end
        end
        S_RNEW: begin
          pc_out  <= npc_q;
          psw_out <= npsw_q;
          sp_out  <= sp_q;
          done    <= 1'b1;
          state   <= S_IDLE;
        end
        S_MERR: begin
          if (in_err) begin
            state <= S_FAIL;
          end else begin
            in_err <= 1'b1;
            vec_q  <= W'(ERR_VEC);
            state  <= S_VPC;
          end
        end
        S_FAIL: begin
          fatal <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trap_seq_top.sv
module trap_seq_top #(
  parameter int W       = 16,
  parameter int STEP    = 2,
  parameter int ERR_VEC = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_trap,
  input  logic         start_ret,
  input  logic         abort_req,
  input  logic         stack_severe,
  input  logic [W-1:0] vec_addr,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] cur_psw,
  input  logic [W-1:0] sp_in,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  input  logic         mem_ack,
  input  logic         mem_err,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] psw_out,
  output logic [W-1:0] sp_out,
  output logic         done,
  output logic         fatal,
  output logic         busy
);
  trap_seq_fsm #(.W(W), .STEP(STEP), .ERR_VEC(ERR_VEC)) u_fsm (
    .clk(clk), .rst(rst),
    .start_trap(start_trap), .start_ret(start_ret),
    .abort_req(abort_req), .stack_severe(stack_severe),
    .vec_addr(vec_addr), .cur_pc(cur_pc), .cur_psw(cur_psw), .sp_in(sp_in),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_out(pc_out), .psw_out(psw_out), .sp_out(sp_out),
    .done(done), .fatal(fatal), .busy(busy)
  );
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_req,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_ack,
  input logic         mem_err,
  input logic         done,
  input logic         fatal,
  input logic         busy
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && (mem_ack || mem_err)) |=> !mem_req);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  fatal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fatal |=> !fatal);

  // R10
  fatal_excl_chk: assert property (@(posedge clk) disable iff (rst)
    fatal |-> !done);
endmodule

bind trap_seq_top trap_seq_chk #(.W(W)) u_chk (.*);

// File: tb/trap_seq_top_tb.sv
module trap_seq_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        start_trap = 0, start_ret = 0, stack_severe = 0;
  logic [15:0] vec_addr = 0, cur_pc = 0, cur_psw = 0;
  logic        mem_req, mem_we, done, fatal, busy;
  logic [15:0] mem_addr, mem_wdata, pc_out, psw_out, sp_out, sp_in, mem_rdata = 0;
  logic        mem_ack = 0, mem_err = 0;
  logic        abort_req;

  // bench memory and control
  logic [15:0] mem [256];
  int          lat = 0, wcnt = 0, n_acc = 0, fault_hits = 0, abort_after = 0;
  logic        clr = 0, reinit = 0, fault_en = 0, fault_once = 0, swap_arm = 0;
  logic [15:0] fault_addr = 0, sp_base = 0, sp_late = 0;
  logic [15:0] lg_addr [16];
  logic [15:0] lg_data [16];
  logic        lg_we   [16];
  logic        lg_err  [16];

  int total = 0, fails = 0;
  logic got_done, got_fatal;

  assign sp_in     = (swap_arm && n_acc >= 1) ? sp_late : sp_base;
  assign abort_req = (abort_after != 0) && (n_acc >= abort_after);

  function automatic logic [15:0] f(input logic [15:0] a);
    return (a * 16'd3) ^ 16'h5A00;
  endfunction

  trap_seq_top u_dut (
    .clk(clk), .rst(rst), .start_trap(start_trap), .start_ret(start_ret),
    .abort_req(abort_req), .stack_severe(stack_severe), .vec_addr(vec_addr),
    .cur_pc(cur_pc), .cur_psw(cur_psw), .sp_in(sp_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .pc_out(pc_out), .psw_out(psw_out), .sp_out(sp_out),
    .done(done), .fatal(fatal), .busy(busy)
  );

  always @(negedge clk) begin
    if (clr) begin
      n_acc = 0; fault_hits = 0; wcnt = 0; mem_ack = 0; mem_err = 0;
      if (reinit) for (int i = 0; i < 256; i++) mem[i] = f(16'(i * 2));
    end else if (mem_ack || mem_err) begin
      mem_ack = 0; mem_err = 0;
    end else if (mem_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        if (fault_en && mem_addr == fault_addr && (!fault_once || fault_hits == 0)) begin
          fault_hits++;
          mem_err = 1;
        end else begin
          mem_ack = 1;
          if (mem_we) mem[mem_addr[8:1]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[8:1]];
        end
        if (n_acc < 16) begin
          lg_addr[n_acc] = mem_addr;
          lg_we[n_acc]   = mem_we;
          lg_data[n_acc] = mem_we ? mem_wdata : mem_rdata;
          lg_err[n_acc]  = mem_err;
        end
        n_acc++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_acc(input string tag, input int i, input logic [15:0] a,
                         input logic we, input logic [15:0] d);
    chk(tag, {lg_addr[i], 15'd0, lg_we[i]}, {a, 15'd0, we});
    if (!lg_err[i]) chk(tag, {16'd0, lg_data[i]}, {16'd0, d});
  endtask

  task automatic prep(input logic ri);
    @(posedge clk); clr = 1; reinit = ri;
    @(posedge clk); clr = 0; reinit = 0;
  endtask

  task automatic run_seq(input logic ret, input logic [15:0] v, pc, psw);
    @(negedge clk);
    vec_addr = v; cur_pc = pc; cur_psw = psw;
    if (ret) start_ret = 1; else start_trap = 1;
    @(negedge clk);
    start_trap = 0; start_ret = 0;
    for (int k = 0; k < 1000; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    got_done = done; got_fatal = fatal;
  endtask

  typedef struct packed {
    logic [15:0] vec, pc, psw, sp;
    logic [3:0]  lat;
    logic        sev;
  } row_t;

  localparam row_t TBL [4] = '{
    '{16'h0040, 16'h1234, 16'h00E0, 16'h01F0, 4'd0, 1'b0},
    '{16'h0080, 16'hBEEF, 16'h0010, 16'h0100, 4'd2, 1'b0},
    '{16'h0010, 16'h0ABC, 16'h00FF, 16'h00C8, 4'd1, 1'b1},
    '{16'h00FC, 16'h7777, 16'h3000, 16'h01A0, 4'd3, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    prep(1);
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 done/fatal", {done, fatal}, 0);
    chk("R1 outputs", {pc_out, psw_out}, 0);
    chk("R1 sp_out", sp_out, 0);

    // R2 R4 R5 R7 table walk
    for (int i = 0; i < 4; i++) begin
      prep(1);
      lat = int'(TBL[i].lat); stack_severe = TBL[i].sev; sp_base = TBL[i].sp;
      run_seq(0, TBL[i].vec, TBL[i].pc, TBL[i].psw);
      chk("R4 done", got_done, 1);
      chk("R2 access count", n_acc, 4);
      chk_acc("R2 vec pc read", 0, TBL[i].vec, 0, f(TBL[i].vec));
      chk_acc("R2 vec psw read", 1, TBL[i].vec + 16'd2, 0, f(TBL[i].vec + 16'd2));
      chk_acc("R7 psw push", 2, TBL[i].sp - 16'd2, 1, TBL[i].sev ? 16'd0 : TBL[i].psw);
      chk_acc("R2 pc push", 3, TBL[i].sp - 16'd4, 1, TBL[i].pc);
      chk("R4 pc_out", pc_out, f(TBL[i].vec));
      chk("R4 psw_out", psw_out, f(TBL[i].vec + 16'd2));
      chk("R4 sp_out", sp_out, TBL[i].sp - 16'd4);
    end
    stack_severe = 0; lat = 1;

    // R3 stack pointer sampled after the vector reads
    prep(1);
    sp_base = 16'h00F0; sp_late = 16'h0140; swap_arm = 1;
    run_seq(0, 16'h0020, 16'h4321, 16'h0007);
    chk_acc("R3 psw push addr", 2, 16'h013E, 1, 16'h0007);
    chk("R3 sp_out", sp_out, 16'h013C);
    swap_arm = 0;

    // R8 round trip: entry then return
    prep(1);
    sp_base = 16'h0180;
    run_seq(0, 16'h0040, 16'h1234, 16'h00E0);
    prep(0);
    sp_base = 16'h017C;
    run_seq(1, 16'h0000, 16'h9999, 16'h8888);
    chk("R8 done", got_done, 1);
    chk("R8 access count", n_acc, 2);
    chk_acc("R8 pc pop", 0, 16'h017C, 0, 16'h1234);
    chk_acc("R8 psw pop", 1, 16'h017E, 0, 16'h00E0);
    chk("R8 pc_out", pc_out, 16'h1234);
    chk("R8 psw_out", psw_out, 16'h00E0);
    chk("R8 sp_out", sp_out, 16'h0180);

    // R6 abort after first and second vector read
    for (int a = 1; a <= 2; a++) begin
      prep(1);
      sp_base = 16'h01C0; abort_after = a;
      run_seq(0, 16'h0060, 16'h5555, 16'h0066);
      chk("R6 no done", got_done, 0);
      chk("R6 busy low", busy, 0);
      chk("R6 access count", n_acc, a);
      chk("R6 outputs kept", sp_out, 16'h0180);
      chk("R6 stack untouched", mem[16'h01BE >> 1], f(16'h01BE));
      abort_after = 0;
    end

    // R9 fault on the status push restarts through vector 4
    prep(1);
    sp_base = 16'h01F0; fault_en = 1; fault_once = 1; fault_addr = 16'h01EE;
    run_seq(0, 16'h0040, 16'h2222, 16'h0055);
    fault_en = 0;
    chk("R9 done", got_done, 1);
    chk("R9 access count", n_acc, 7);
    chk("R9 err seen", lg_err[2], 1);
    chk_acc("R9 vec4 read", 3, 16'h0004, 0, f(16'h0004));
    chk_acc("R9 vec6 read", 4, 16'h0006, 0, f(16'h0006));
    chk_acc("R9 psw push", 5, 16'h01EE, 1, 16'h0055);
    chk_acc("R9 pc push", 6, 16'h01EC, 1, 16'h2222);
    chk("R9 pc_out", pc_out, f(16'h0004));
    chk("R9 sp_out", sp_out, 16'h01EC);

    // R10 fault inside the bus-error entry
    prep(1);
    fault_en = 1; fault_once = 0; fault_addr = 16'h0004;
    run_seq(0, 16'h0004, 16'h3333, 16'h0011);
    fault_en = 0;
    chk("R10 fatal", got_fatal, 1);
    chk("R10 no done", got_done, 0);
    chk("R10 access count", n_acc, 2);
    chk("R10 idle", busy, 0);

    // R10 block recovers for a clean entry afterwards
    prep(1);
    sp_base = 16'h0100;
    run_seq(0, 16'h0030, 16'h0101, 16'h0202);
    chk("R10 recovery done", got_done, 1);
    chk("R10 recovery pc_out", pc_out, f(16'h0030));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule